// File: doc/BRIEF.md
# Time-Shared Dual-Port Packet Buffer

This block is a 512-byte packet store, organised as 256 halfwords of 16 bits, shared by two masters. A processor reaches it through an APB slave port. A USB protocol engine reaches it through a 16-bit request/acknowledge port. The same storage holds the packet data and the per-endpoint descriptor entries, which give each endpoint's buffer start, buffer size and byte count. The block only stores and arbitrates. It does not interpret those entries.

The block runs on `clk`, which is twice the rate of the APB bus clock. Each APB cycle is therefore two `clk` cycles. A two-state slot sequencer alternates between them. State `SLOT_CPU` serves the APB side, and state `SLOT_USB` serves the USB side. The transitions are fixed: `SLOT_CPU -> SLOT_USB` and `SLOT_USB -> SLOT_CPU`, one per `clk` edge. Neither master can crowd out the other. The USB port has a second two-state machine:

- `UP_IDLE -> UP_ACK` when a request is served in a USB slot.
- `UP_ACK -> UP_IDLE` unconditionally on the next edge.

On the APB side the window is 1 KB wide and sparse. Each 32-bit word location carries one storage halfword in its low 16 bits. The APB master must present an access aligned to a slot pair: it starts in a `SLOT_CPU` cycle and holds for two `clk` cycles. The APB clock is expected to run above 8 MHz, so that the USB engine is served in time.

Top module: `usb_pkt_buffer`

## Requirements
- R1: While reset is asserted, `slot_is_usb` is 0, `usb_ack` is 0 and `apb_pready` is 1. Reset clears only sequencing state. Storage contents are undefined until written.
- R2: After reset, `slot_is_usb` inverts on every `clk` edge. 0 means the CPU slot and 1 means the USB slot.
- R3: An APB write with `apb_psel`=1, `apb_penable`=1 and `apb_pwrite`=1, sampled at the edge that ends a CPU slot, stores `apb_pwdata[15:0]` into halfword index `apb_paddr[9:2]`. Bits `apb_pwdata[31:16]` and `apb_paddr[1:0]` are ignored.
- R4: An APB read, with the same qualifiers and `apb_pwrite`=0, places the addressed halfword on `apb_prdata[15:0]` with `apb_prdata[31:16]`=0. The value is valid from the following USB-slot cycle and stays there until the next APB read completes.
- R5: An APB transfer with `apb_penable`=0 has no effect on storage.
- R6: `apb_pready` is always 1.
- R7: A USB request (`usb_req`=1, with `usb_we` selecting write when 1) is served only at the edge that ends a USB slot. `usb_ack` is then high for exactly one cycle, the CPU-slot cycle that follows.
- R8: A USB request raised during a CPU slot is held off until the next USB slot. It is acknowledged 2 `clk` cycles after it is raised.
- R9: For a USB read, `usb_rdata` carries the halfword at `usb_addr` while `usb_ack` is high, and holds it until the next USB read.
- R10: When both sides write the same halfword within one APB cycle, the USB value remains stored.
- R11: Back-to-back APB accesses in every CPU slot never delay a USB request: it is still acknowledged within 2 cycles.
- R12: Both ports address the same storage. A halfword written through one port reads back through the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; two cycles per APB cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| apb_psel | input | 1 | APB select |
| apb_penable | input | 1 | APB enable (access phase) |
| apb_pwrite | input | 1 | APB direction, 1 = write |
| apb_paddr | input | 10 | APB byte address within the 1 KB window |
| apb_pwdata | input | 32 | APB write data; only [15:0] is stored |
| apb_prdata | output | 32 | APB read data, zero-extended halfword |
| apb_pready | output | 1 | Always 1, no wait states |
| usb_req | input | 1 | USB engine access request, held until ack |
| usb_we | input | 1 | USB access direction, 1 = write |
| usb_addr | input | 8 | USB halfword index |
| usb_wdata | input | 16 | USB write data |
| usb_rdata | output | 16 | USB read data |
| usb_ack | output | 1 | One-cycle acknowledge of a served USB request |
| slot_is_usb | output | 1 | Current slot: 0 = CPU, 1 = USB |

## Verification
The bench writes one halfword from both sides within the same APB cycle. A design that ordered the slots the wrong way round would leave the APB value in storage instead of the USB value. It sends writes whose upper data bits and low address bits are non-zero. A design that decoded the wrong address bits would place the data in the wrong halfword. A design that did not mask the data would return non-zero upper read bits. It raises a USB request during a CPU slot, and also keeps the APB side busy in every CPU slot. A design that served the engine early, late or twice would show the acknowledge in the wrong cycle, or hold it for more than one cycle. A transfer with enable low is also sent, and must leave the stored value untouched.

// File: rtl/usb_pb_pkg.sv
package usb_pb_pkg;
    localparam int unsigned PB_BYTES   = 512;
    localparam int unsigned PB_HW_W    = 16;
    localparam int unsigned PB_DEPTH   = PB_BYTES / (PB_HW_W / 8);
    localparam int unsigned PB_IDX_W   = $clog2(PB_DEPTH);
    localparam int unsigned APB_DW     = 32;
    localparam int unsigned APB_AW     = PB_IDX_W + 2;

    typedef enum logic {
        SLOT_CPU = 1'b0,
        SLOT_USB = 1'b1
    } slot_e;

    typedef enum logic {
        UP_IDLE = 1'b0,
        UP_ACK  = 1'b1
    } uport_e;
endpackage

// File: rtl/pb_slot_seq.sv
module pb_slot_seq
    import usb_pb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_e slot
);
    slot_e state_q;
    slot_e state_d;

    always_comb begin
        unique case (state_q)
            SLOT_CPU: state_d = SLOT_USB;
            SLOT_USB: state_d = SLOT_CPU;
            default:  state_d = SLOT_CPU;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_CPU;
        else        state_q <= state_d;
    end

    assign slot = state_q;
endmodule

// File: rtl/pb_usb_port.sv
module pb_usb_port
    import usb_pb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  slot_e slot,
    input  logic  req,
    output logic  serve,
    output logic  ack
);
    uport_e state_q;
    uport_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UP_IDLE: if (slot == SLOT_USB && req) state_d = UP_ACK;
            UP_ACK:  state_d = UP_IDLE;
            default: state_d = UP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        serve = 1'b0;
        ack   = 1'b0;
        unique case (state_q)
            UP_IDLE: serve = (slot == SLOT_USB) && req;
            UP_ACK:  ack   = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/pb_apb_window.sv
module pb_apb_window
    import usb_pb_pkg::*;
#(
    parameter int unsigned AW  = APB_AW,
    parameter int unsigned DW  = APB_DW,
    parameter int unsigned HW  = PB_HW_W,
    localparam int unsigned IW = AW - 2
) (
    input  slot_e          slot,
    input  logic           psel,
    input  logic           penable,
    input  logic           pwrite,
    input  logic [AW-1:0]  paddr,
    input  logic [DW-1:0]  pwdata,
    input  logic [HW-1:0]  hw_rd,
    output logic           hit,
    output logic           hit_we,
    output logic [IW-1:0]  idx,
    output logic [HW-1:0]  hw_wr,
    output logic [DW-1:0]  prdata
);
    assign hit    = psel && penable && (slot == SLOT_CPU);
    assign hit_we = hit && pwrite;
    assign idx    = paddr[AW-1:2];
    assign hw_wr  = pwdata[HW-1:0];
    assign prdata = {{(DW-HW){1'b0}}, hw_rd};
endmodule

// File: rtl/pb_storage.sv
module pb_storage #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned DW    = 16,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          we,
    input  logic          to_usb,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_cpu_q,
    output logic [DW-1:0] rd_usb_q
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en && we) mem[idx] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_cpu_q <= '0;
            rd_usb_q <= '0;
        end else if (en && !we) begin
            if (to_usb) rd_usb_q <= mem[idx];
            else        rd_cpu_q <= mem[idx];
        end
    end
endmodule

// File: rtl/usb_pkt_buffer.sv
module usb_pkt_buffer
    import usb_pb_pkg::*;
#(
    parameter int unsigned DEPTH = PB_DEPTH,
    parameter int unsigned HW    = PB_HW_W,
    parameter int unsigned DW    = APB_DW,
    localparam int unsigned IW   = $clog2(DEPTH),
    localparam int unsigned AW   = IW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          apb_psel,
    input  logic          apb_penable,
    input  logic          apb_pwrite,
    input  logic [AW-1:0] apb_paddr,
    input  logic [DW-1:0] apb_pwdata,
    output logic [DW-1:0] apb_prdata,
    output logic          apb_pready,
    input  logic          usb_req,
    input  logic          usb_we,
    input  logic [IW-1:0] usb_addr,
    input  logic [HW-1:0] usb_wdata,
    output logic [HW-1:0] usb_rdata,
    output logic          usb_ack,
    output logic          slot_is_usb
);
    slot_e         slot;
    logic          cpu_hit;
    logic          cpu_we;
    logic [IW-1:0] cpu_idx;
    logic [HW-1:0] cpu_wd;
    logic [HW-1:0] cpu_rd;
    logic          usb_serve;
    logic          mem_en;
    logic          mem_we;
    logic [IW-1:0] mem_idx;
    logic [HW-1:0] mem_wd;

    pb_slot_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot)
    );

    pb_usb_port u_uport (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot),
        .req   (usb_req),
        .serve (usb_serve),
        .ack   (usb_ack)
    );

    pb_apb_window #(.AW(AW), .DW(DW), .HW(HW)) u_win (
        .slot    (slot),
        .psel    (apb_psel),
        .penable (apb_penable),
        .pwrite  (apb_pwrite),
        .paddr   (apb_paddr),
        .pwdata  (apb_pwdata),
        .hw_rd   (cpu_rd),
        .hit     (cpu_hit),
        .hit_we  (cpu_we),
        .idx     (cpu_idx),
        .hw_wr   (cpu_wd),
        .prdata  (apb_prdata)
    );

    always_comb begin
        unique case (slot)
            SLOT_CPU: begin
                mem_en  = cpu_hit;
                mem_we  = cpu_we;
                mem_idx = cpu_idx;
                mem_wd  = cpu_wd;
            end
            SLOT_USB: begin
                mem_en  = usb_serve;
                mem_we  = usb_we;
                mem_idx = usb_addr;
                mem_wd  = usb_wdata;
            end
            default: begin
                mem_en  = 1'b0;
                mem_we  = 1'b0;
                mem_idx = '0;
                mem_wd  = '0;
            end
        endcase
    end

    pb_storage #(.DEPTH(DEPTH), .DW(HW)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mem_en),
        .we       (mem_we),
        .to_usb   (slot == SLOT_USB),
        .idx      (mem_idx),
        .wdata    (mem_wd),
        .rd_cpu_q (cpu_rd),
        .rd_usb_q (usb_rdata)
    );

    assign apb_pready  = 1'b1;
    assign slot_is_usb = (slot == SLOT_USB);
endmodule

// File: rtl/usb_pkt_buffer_chk.sv
module usb_pkt_buffer_chk #(
    parameter int unsigned DW = 32,
    parameter int unsigned HW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          slot_is_usb,
    input logic          usb_req,
    input logic          usb_ack,
    input logic          apb_pready,
    input logic [DW-1:0] apb_prdata,
    input logic [HW-1:0] usb_rdata
);
    a_r2_slot_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> slot_is_usb != $past(slot_is_usb));

    a_r7_ack_follows_usb_slot: assert property (@(posedge clk) disable iff (!rst_n)
        usb_ack |-> (!slot_is_usb && $past(slot_is_usb) && $past(usb_req)));

    a_r7_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        usb_ack |=> !usb_ack);

    a_r8_no_service_in_cpu_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_is_usb && usb_req && !usb_ack) |=> !usb_ack);

    a_r6_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
        apb_pready);

    a_r4_prdata_held_over_usb_slot: assert property (@(posedge clk) disable iff (!rst_n)
        slot_is_usb |=> $stable(apb_prdata));

    a_r9_usb_rdata_held_over_cpu_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_is_usb |=> $stable(usb_rdata));
endmodule

bind usb_pkt_buffer usb_pkt_buffer_chk #(.DW(DW), .HW(HW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_is_usb (slot_is_usb),
    .usb_req     (usb_req),
    .usb_ack     (usb_ack),
    .apb_pready  (apb_pready),
    .apb_prdata  (apb_prdata),
    .usb_rdata   (usb_rdata)
);

// File: tb/usb_pkt_buffer_bench.sv
module usb_pkt_buffer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        apb_psel = 1'b0, apb_penable = 1'b0, apb_pwrite = 1'b0;
    logic [9:0]  apb_paddr = '0;
    logic [31:0] apb_pwdata = '0;
    logic [31:0] apb_prdata;
    logic        apb_pready;
    logic        usb_req = 1'b0, usb_we = 1'b0;
    logic [7:0]  usb_addr = '0;
    logic [15:0] usb_wdata = '0;
    logic [15:0] usb_rdata;
    logic        usb_ack;
    logic        slot_is_usb;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    usb_pkt_buffer u_usb_pkt_buffer (
        .clk(clk), .rst_n(rst_n),
        .apb_psel(apb_psel), .apb_penable(apb_penable), .apb_pwrite(apb_pwrite),
        .apb_paddr(apb_paddr), .apb_pwdata(apb_pwdata), .apb_prdata(apb_prdata),
        .apb_pready(apb_pready),
        .usb_req(usb_req), .usb_we(usb_we), .usb_addr(usb_addr),
        .usb_wdata(usb_wdata), .usb_rdata(usb_rdata), .usb_ack(usb_ack),
        .slot_is_usb(slot_is_usb)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic to_cpu_slot();
        @(negedge clk);
        while (slot_is_usb) @(negedge clk);
    endtask

    task automatic apb_idle();
        apb_psel = 0; apb_penable = 0; apb_pwrite = 0;
    endtask

    task automatic apb_wr(input logic [9:0] a, input logic [31:0] d, input logic en);
        to_cpu_slot();
        apb_psel = 1; apb_penable = en; apb_pwrite = 1; apb_paddr = a; apb_pwdata = d;
        @(negedge clk);
        @(negedge clk);
        apb_idle();
    endtask

    task automatic apb_rd(input logic [9:0] a, output logic [31:0] d);
        to_cpu_slot();
        apb_psel = 1; apb_penable = 1; apb_pwrite = 0; apb_paddr = a;
        @(negedge clk);
        d = apb_prdata;
        @(negedge clk);
        apb_idle();
    endtask

    task automatic usb_op(input logic we, input logic [7:0] a, input logic [15:0] d,
                          output int waited, output logic [15:0] rd);
        usb_req = 1; usb_we = we; usb_addr = a; usb_wdata = d;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!usb_ack && waited < 20);
        rd = usb_rdata;
        usb_req = 0;
        @(negedge clk);
        check("R7 ack lasts one cycle", {31'b0, usb_ack}, 32'd0);
    endtask

    task automatic t_reset();
        #5;
        check("R1 slot in reset", {31'b0, slot_is_usb}, 32'd0);
        check("R1 ack in reset", {31'b0, usb_ack}, 32'd0);
        check("R1 pready in reset", {31'b0, apb_pready}, 32'd1);
    endtask

    task automatic t_slot_toggle();
        logic prev;
        @(negedge clk); prev = slot_is_usb;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R2 slot toggles", {31'b0, slot_is_usb}, {31'b0, ~prev});
            check("R6 pready high", {31'b0, apb_pready}, 32'd1);
            prev = slot_is_usb;
        end
    endtask

    task automatic t_apb_rw();
        logic [31:0] d;
        apb_wr(10'h013, 32'hDEAD_1234, 1'b1);
        apb_rd(10'h010, d);
        check("R3 R4 write index 4 read back", d, 32'h0000_1234);
        apb_wr(10'h3FC, 32'hFFFF_A5C3, 1'b1);
        apb_rd(10'h3FE, d);
        check("R3 top index, upper bits dropped", d, 32'h0000_A5C3);
        apb_rd(10'h010, d);
        check("R3 neighbour untouched", d, 32'h0000_1234);
    endtask

    task automatic t_no_enable();
        logic [31:0] d;
        apb_wr(10'h010, 32'h0000_9999, 1'b0);
        apb_rd(10'h010, d);
        check("R5 penable low ignored", d, 32'h0000_1234);
    endtask

    task automatic t_usb_timing();
        int w;
        logic [15:0] rd;
        to_cpu_slot();
        usb_op(1'b1, 8'h20, 16'hBEEF, w, rd);
        check("R8 req in CPU slot acked after 2 cycles", w, 32'd2);
        @(negedge clk);
        while (!slot_is_usb) @(negedge clk);
        usb_op(1'b0, 8'h20, 16'h0, w, rd);
        check("R7 req in USB slot acked next cycle", w, 32'd1);
        check("R9 usb read data at ack", {16'b0, rd}, 32'h0000_BEEF);
    endtask

    task automatic t_shared();
        int w;
        logic [15:0] rd;
        logic [31:0] d;
        apb_rd(10'h080, d);
        check("R12 USB write seen by APB", d, 32'h0000_BEEF);
        apb_wr(10'h0A0, 32'h0000_7777, 1'b1);
        to_cpu_slot();
        usb_op(1'b0, 8'h28, 16'h0, w, rd);
        check("R12 APB write seen by USB", {16'b0, rd}, 32'h0000_7777);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        to_cpu_slot();
        apb_psel = 1; apb_penable = 1; apb_pwrite = 1; apb_paddr = 10'h0C0; apb_pwdata = 32'h0000_1111;
        usb_req = 1; usb_we = 1; usb_addr = 8'h30; usb_wdata = 16'h2222;
        @(negedge clk);
        @(negedge clk);
        check("R10 ack after collision slot", {31'b0, usb_ack}, 32'd1);
        apb_idle(); usb_req = 0;
        apb_rd(10'h0C0, d);
        check("R10 USB write wins", d, 32'h0000_2222);
    endtask

    task automatic t_busy_cpu();
        int w;
        to_cpu_slot();
        apb_psel = 1; apb_penable = 1; apb_pwrite = 0; apb_paddr = 10'h010;
        usb_req = 1; usb_we = 0; usb_addr = 8'h04;
        w = 0;
        do begin
            @(negedge clk);
            w++;
        end while (!usb_ack && w < 20);
        check("R11 USB served despite busy APB", w, 32'd2);
        check("R11 usb data", {16'b0, usb_rdata}, 32'h0000_1234);
        usb_req = 0;
        @(negedge clk);
        @(negedge clk);
        check("R4 APB read during busy run", apb_prdata, 32'h0000_1234);
        apb_idle();
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        #40 rst_n = 1'b1;
        t_slot_toggle();
        t_apb_rw();
        t_no_enable();
        t_usb_timing();
        t_shared();
        t_collision();
        t_busy_cpu();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule